// File: doc/BRIEF.md
# Scatter-Gather Sector DMA Walker

This block moves fixed-size disk sectors (512 bytes by default) between a drive data port and system memory. It does not use one contiguous buffer. It follows a chain of region descriptors stored in memory. Each descriptor is two 32-bit words. The first word gives the region's start address. The second word gives the region's byte length, and its top bit marks the final descriptor of the chain. The block reads descriptors through a word-wide memory read port, one word at a time. It then streams data one byte per beat. A sector may begin in one region and finish in another, and the walker fetches the next descriptor in the middle of the sector when it needs to.

Two channel contexts are held side by side. Each context holds a descriptor pointer, the current address, the remaining region count, a final-descriptor flag, an active flag and a fault flag. A pulse on the start input loads a channel's pointer from the table base and fetches its first descriptor at once. Each sector request names a channel and a direction. The request ends with a single response pulse that carries an error bit.

All byte streams use valid/ready, and a byte moves only in a cycle where both are high. In the drive-to-memory direction, the memory write valid follows the drive's valid, and the drive's ready follows the memory's ready. In the memory-to-drive direction, the memory read request is raised only while the drive is ready. The memory returns the byte in the same cycle it asserts ready. Either side may stall for any number of cycles without losing or repeating a byte. Descriptor requests hold their address until accepted. At most one descriptor read is outstanding, and its data arrives on a later cycle that is marked by the data-valid input.

Top module: `sgdma_walker`

## Requirements
- R1: A start pulse is taken only while `busy_o` is low. It has precedence over a sector request in the same cycle. It clears the channel's fault flag and reads descriptor words at the table base and base+4. It then sets the channel's active flag.
- R2: The region address is descriptor word 0 with bit 0 forced to 0. The region count is bits 15:1 of word 1 with bit 0 forced to 0. A count field of zero means 65536 bytes. Bit 31 of word 1 marks the final descriptor.
- R3: Every descriptor fetch advances the channel's descriptor pointer by 8, so the next descriptor is read at the following 8-byte slot.
- R4: A sector request moves exactly 512 bytes to or from consecutive addresses. When a region runs out before the sector ends and the region is not the final one, the walker fetches the next descriptor and continues there.
- R5: When the final region's count reaches zero, the channel's active flag clears. The sector completes with a response pulse whose error bit is 0.
- R6: A sector request on an inactive channel produces a response with the error bit set and moves no bytes.
- R7: If the current region is the final one and holds fewer bytes than the sector still needs, no byte moves. The fault flag sets, the active flag clears, and the response carries the error bit.
- R8: The two channels keep independent contexts. A sector on one channel leaves the other channel's position untouched.
- R9: Direction 0 moves bytes from the drive input stream to the memory write stream. Direction 1 moves bytes from the memory read stream to the drive output stream. The stream for the unused direction never handshakes.
- R10: A byte transfers only on a valid/ready handshake. Stalls on either side lose no byte and repeat no byte.
- R11: After reset, no channel is active or faulted, no valid or response is raised, and a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for a channel |
| start_ch_i | input | 1 | Channel to start |
| table_base_i | input | 32 | Address of the channel's first descriptor |
| busy_o | output | 1 | Walker engaged in a fetch or a sector |
| active_o | output | 2 | Per-channel active flags |
| fault_o | output | 2 | Per-channel fault flags |
| req_valid_i | input | 1 | Sector request valid |
| req_ready_o | output | 1 | Sector request accepted |
| req_ch_i | input | 1 | Channel of the sector request |
| req_dir_i | input | 1 | 0: drive to memory, 1: memory to drive |
| resp_valid_o | output | 1 | One-cycle completion pulse |
| resp_err_o | output | 1 | Error bit of the completion |
| dq_valid_o | output | 1 | Descriptor word read request |
| dq_ready_i | input | 1 | Descriptor read request accepted |
| dq_addr_o | output | 32 | Descriptor word address |
| dr_valid_i | input | 1 | Descriptor word data valid |
| dr_data_i | input | 32 | Descriptor word data |
| dv_in_valid_i | input | 1 | Drive byte available |
| dv_in_ready_o | output | 1 | Drive byte taken |
| dv_in_data_i | input | 8 | Byte from the drive |
| dv_out_valid_o | output | 1 | Byte offered to the drive |
| dv_out_ready_i | input | 1 | Drive accepts a byte |
| dv_out_data_o | output | 8 | Byte to the drive |
| mw_valid_o | output | 1 | Memory byte write valid |
| mw_ready_i | input | 1 | Memory byte write accepted |
| mw_addr_o | output | 32 | Memory write address |
| mw_data_o | output | 8 | Memory write byte |
| mr_valid_o | output | 1 | Memory byte read request |
| mr_ready_i | input | 1 | Memory read done, data present |
| mr_addr_o | output | 32 | Memory read address |
| mr_data_i | input | 8 | Memory read byte |

## Verification
Two pairs of functions can fall in the same cycle. First, a start pulse can meet a pending sector request while the walker is idle. The bench raises both on the same edge and checks three things: the request is held off, the start's descriptor fetch runs first, and the request then receives its own response. Second, the last byte of a non-final region can coincide with the middle of a sector. Region lengths of 100 and 300 bytes force this in the first sector. The bench judges it by comparing every byte address against an address sequence it computes from the chain, with random stalls on every stream.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam int unsigned SG_AW       = 32;
  localparam int unsigned SG_DW       = 32;
  localparam int unsigned CNT_FIELD_W = 16;
  localparam int unsigned CNT_W       = CNT_FIELD_W + 1;
  localparam int unsigned LAST_BIT    = 31;
  localparam int unsigned DESC_BYTES  = 8;
  localparam int unsigned WORD_BYTES  = 4;
  localparam logic DIR_TO_MEM   = 1'b0;
  localparam logic DIR_TO_DRIVE = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_A, ST_WAIT_A, ST_FETCH_B, ST_WAIT_B, ST_SYNC, ST_MOVE, ST_RESP
  } walk_state_t;

  typedef struct packed {
    logic             active;
    logic             fault;
    logic             last;
    logic [CNT_W-1:0] count;
    logic [SG_AW-1:0] addr;
    logic [SG_AW-1:0] ptr;
  } chan_ctx_t;
endpackage

// File: rtl/sgdma_ctx_bank.sv
module sgdma_ctx_bank
  import sgdma_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [CH_W-1:0]        wch_i,
  input  chan_ctx_t              wd_i,
  output chan_ctx_t [NUM_CH-1:0] q_o
);
  chan_ctx_t slot_q [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[c] <= '0;
      end else if (we_i && (wch_i == CH_W'(c))) begin
        slot_q[c] <= wd_i;
      end
    end
    assign q_o[c] = slot_q[c];
  end
endmodule

// File: rtl/sgdma_byte_path.sv
module sgdma_byte_path
  import sgdma_pkg::*;
(
  input  logic       xfer_i,
  input  logic       dir_i,
  input  logic       dv_in_valid_i,
  output logic       dv_in_ready_o,
  input  logic [7:0] dv_in_data_i,
  output logic       dv_out_valid_o,
  input  logic       dv_out_ready_i,
  output logic [7:0] dv_out_data_o,
  output logic       mw_valid_o,
  input  logic       mw_ready_i,
  output logic [7:0] mw_data_o,
  output logic       mr_valid_o,
  input  logic       mr_ready_i,
  input  logic [7:0] mr_data_i,
  output logic       beat_o
);
  logic to_mem, to_drv;

  assign to_mem = xfer_i && (dir_i == DIR_TO_MEM);
  assign to_drv = xfer_i && (dir_i == DIR_TO_DRIVE);

  // drive -> memory: valid forwarded downstream, ready forwarded upstream
  assign mw_valid_o    = to_mem && dv_in_valid_i;
  assign dv_in_ready_o = to_mem && mw_ready_i;
  assign mw_data_o     = dv_in_data_i;

  // memory -> drive: read only requested while the drive can take the byte
  assign mr_valid_o     = to_drv && dv_out_ready_i;
  assign dv_out_valid_o = mr_valid_o && mr_ready_i;
  assign dv_out_data_o  = mr_data_i;

  assign beat_o = (mw_valid_o && mw_ready_i) || (mr_valid_o && mr_ready_i);
endmodule

// File: rtl/sgdma_ctrl.sv
module sgdma_ctrl
  import sgdma_pkg::*;
#(
  parameter int unsigned NUM_CH       = 2,
  parameter int unsigned SECTOR_BYTES = 512,
  parameter int unsigned CH_W         = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [CH_W-1:0]        start_ch_i,
  input  logic [SG_AW-1:0]       table_base_i,
  input  logic                   req_valid_i,
  input  logic [CH_W-1:0]        req_ch_i,
  input  logic                   req_dir_i,
  output logic                   req_ready_o,
  output logic                   resp_valid_o,
  output logic                   resp_err_o,
  output logic                   busy_o,
  output logic                   dq_valid_o,
  input  logic                   dq_ready_i,
  output logic [SG_AW-1:0]       dq_addr_o,
  input  logic                   dr_valid_i,
  input  logic [SG_DW-1:0]       dr_data_i,
  input  chan_ctx_t [NUM_CH-1:0] ctx_q_i,
  output logic                   ctx_we_o,
  output logic [CH_W-1:0]        ctx_ch_o,
  output chan_ctx_t              ctx_wd_o,
  output logic                   xfer_o,
  output logic                   dir_o,
  output logic [SG_AW-1:0]       mem_addr_o,
  input  logic                   beat_i
);
  localparam int unsigned REM_W = $clog2(SECTOR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_WRAP = {1'b1, {CNT_FIELD_W{1'b0}}};

  walk_state_t      state_q;
  chan_ctx_t        work_q;
  chan_ctx_t        start_ctx;
  logic [CH_W-1:0]  ch_q;
  logic             dir_q;
  logic             err_q;
  logic             from_start_q;
  logic [REM_W-1:0] rem_q;
  logic [CNT_FIELD_W-1:0] cnt_field;
  logic             short_region;
  logic             unused_bits;

  assign unused_bits = ^{dr_data_i[LAST_BIT-1:CNT_FIELD_W], dr_data_i[0]};
  assign cnt_field   = {dr_data_i[CNT_FIELD_W-1:1], 1'b0};

  always_comb begin
    start_ctx        = ctx_q_i[start_ch_i];
    start_ctx.ptr    = table_base_i;
    start_ctx.fault  = 1'b0;
    start_ctx.active = 1'b0;
  end

  // final region cannot cover what the sector still needs
  assign short_region = work_q.last && (work_q.count < CNT_W'(rem_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      work_q       <= '0;
      ch_q         <= '0;
      dir_q        <= 1'b0;
      err_q        <= 1'b0;
      from_start_q <= 1'b0;
      rem_q        <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            ch_q         <= start_ch_i;
            work_q       <= start_ctx;
            from_start_q <= 1'b1;
            state_q      <= ST_FETCH_A;
          end else if (req_valid_i) begin
            ch_q         <= req_ch_i;
            dir_q        <= req_dir_i;
            work_q       <= ctx_q_i[req_ch_i];
            from_start_q <= 1'b0;
            rem_q        <= REM_W'(SECTOR_BYTES);
            if (!ctx_q_i[req_ch_i].active) begin
              err_q   <= 1'b1;
              state_q <= ST_RESP;
            end else begin
              err_q   <= 1'b0;
              state_q <= ST_MOVE;
            end
          end
        end
        ST_FETCH_A: if (dq_ready_i) state_q <= ST_WAIT_A;
        ST_WAIT_A: begin
          if (dr_valid_i) begin
            work_q.addr <= {dr_data_i[SG_AW-1:1], 1'b0};
            state_q     <= ST_FETCH_B;
          end
        end
        ST_FETCH_B: if (dq_ready_i) state_q <= ST_WAIT_B;
        ST_WAIT_B: begin
          if (dr_valid_i) begin
            work_q.count <= (cnt_field == '0) ? CNT_WRAP : {1'b0, cnt_field};
            work_q.last  <= dr_data_i[LAST_BIT];
            work_q.ptr   <= work_q.ptr + SG_AW'(DESC_BYTES);
            if (from_start_q) begin
              work_q.active <= 1'b1;
              state_q       <= ST_SYNC;
            end else if (rem_q == '0) begin
              state_q <= ST_RESP;
            end else begin
              state_q <= ST_MOVE;
            end
          end
        end
        ST_SYNC: state_q <= ST_IDLE;
        ST_MOVE: begin
          if (short_region) begin
            work_q.fault  <= 1'b1;
            work_q.active <= 1'b0;
            err_q         <= 1'b1;
            state_q       <= ST_RESP;
          end else if (beat_i) begin
            work_q.addr  <= work_q.addr + SG_AW'(1);
            work_q.count <= work_q.count - CNT_W'(1);
            rem_q        <= rem_q - REM_W'(1);
            if (work_q.count == CNT_W'(1)) begin
              if (work_q.last) begin
                work_q.active <= 1'b0;
                state_q       <= ST_RESP;
              end else begin
                state_q <= ST_FETCH_A;
              end
            end else if (rem_q == REM_W'(1)) begin
              state_q <= ST_RESP;
            end
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign req_ready_o  = (state_q == ST_IDLE) && !start_i;
  assign resp_valid_o = (state_q == ST_RESP);
  assign resp_err_o   = (state_q == ST_RESP) && err_q;
  assign dq_valid_o   = (state_q == ST_FETCH_A) || (state_q == ST_FETCH_B);
  assign dq_addr_o    = (state_q == ST_FETCH_B) ? work_q.ptr + SG_AW'(WORD_BYTES) : work_q.ptr;
  assign ctx_we_o     = (state_q != ST_IDLE);
  assign ctx_ch_o     = ch_q;
  assign ctx_wd_o     = work_q;
  assign xfer_o       = (state_q == ST_MOVE) && !short_region;
  assign dir_o        = dir_q;
  assign mem_addr_o   = work_q.addr;
endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
  import sgdma_pkg::*;
#(
  parameter int unsigned NUM_CH       = 2,
  parameter int unsigned SECTOR_BYTES = 512,
  parameter int unsigned CH_W         = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [CH_W-1:0]    start_ch_i,
  input  logic [SG_AW-1:0]   table_base_i,
  output logic               busy_o,
  output logic [NUM_CH-1:0]  active_o,
  output logic [NUM_CH-1:0]  fault_o,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [CH_W-1:0]    req_ch_i,
  input  logic               req_dir_i,
  output logic               resp_valid_o,
  output logic               resp_err_o,
  output logic               dq_valid_o,
  input  logic               dq_ready_i,
  output logic [SG_AW-1:0]   dq_addr_o,
  input  logic               dr_valid_i,
  input  logic [SG_DW-1:0]   dr_data_i,
  input  logic               dv_in_valid_i,
  output logic               dv_in_ready_o,
  input  logic [7:0]         dv_in_data_i,
  output logic               dv_out_valid_o,
  input  logic               dv_out_ready_i,
  output logic [7:0]         dv_out_data_o,
  output logic               mw_valid_o,
  input  logic               mw_ready_i,
  output logic [SG_AW-1:0]   mw_addr_o,
  output logic [7:0]         mw_data_o,
  output logic               mr_valid_o,
  input  logic               mr_ready_i,
  output logic [SG_AW-1:0]   mr_addr_o,
  input  logic [7:0]         mr_data_i
);
  chan_ctx_t [NUM_CH-1:0] ctx_q;
  chan_ctx_t              ctx_wd;
  logic                   ctx_we;
  logic [CH_W-1:0]        ctx_ch;
  logic                   xfer, dir, beat;
  logic [SG_AW-1:0]       mem_addr;

  sgdma_ctx_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we_i(ctx_we), .wch_i(ctx_ch), .wd_i(ctx_wd), .q_o(ctx_q)
  );

  sgdma_ctrl #(.NUM_CH(NUM_CH), .SECTOR_BYTES(SECTOR_BYTES), .CH_W(CH_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_i), .start_ch_i(start_ch_i), .table_base_i(table_base_i),
    .req_valid_i(req_valid_i), .req_ch_i(req_ch_i), .req_dir_i(req_dir_i),
    .req_ready_o(req_ready_o), .resp_valid_o(resp_valid_o), .resp_err_o(resp_err_o),
    .busy_o(busy_o),
    .dq_valid_o(dq_valid_o), .dq_ready_i(dq_ready_i), .dq_addr_o(dq_addr_o),
    .dr_valid_i(dr_valid_i), .dr_data_i(dr_data_i),
    .ctx_q_i(ctx_q), .ctx_we_o(ctx_we), .ctx_ch_o(ctx_ch), .ctx_wd_o(ctx_wd),
    .xfer_o(xfer), .dir_o(dir), .mem_addr_o(mem_addr), .beat_i(beat)
  );

  sgdma_byte_path u_path (
    .xfer_i(xfer), .dir_i(dir),
    .dv_in_valid_i(dv_in_valid_i), .dv_in_ready_o(dv_in_ready_o), .dv_in_data_i(dv_in_data_i),
    .dv_out_valid_o(dv_out_valid_o), .dv_out_ready_i(dv_out_ready_i), .dv_out_data_o(dv_out_data_o),
    .mw_valid_o(mw_valid_o), .mw_ready_i(mw_ready_i), .mw_data_o(mw_data_o),
    .mr_valid_o(mr_valid_o), .mr_ready_i(mr_ready_i), .mr_data_i(mr_data_i),
    .beat_o(beat)
  );

  assign mw_addr_o = mem_addr;
  assign mr_addr_o = mem_addr;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flags
    assign active_o[c] = ctx_q[c].active;
    assign fault_o[c]  = ctx_q[c].fault;
  end
endmodule

// File: rtl/sgdma_walker_chk.sv
module sgdma_walker_chk
  import sgdma_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic [NUM_CH-1:0] active_o,
  input logic [NUM_CH-1:0] fault_o,
  input logic              req_ready_o,
  input logic              resp_valid_o,
  input logic              dq_valid_o,
  input logic              dq_ready_i,
  input logic [SG_AW-1:0]  dq_addr_o,
  input logic              mw_valid_o,
  input logic              mr_valid_o
);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(mw_valid_o || mr_valid_o || dq_valid_o));

  assert_one_direction_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mw_valid_o && mr_valid_o));

  assert_resp_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid_o |=> !resp_valid_o);

  assert_fault_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o & active_o) == '0);

  assert_desc_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_valid_o && !dq_ready_i) |=> (dq_valid_o && $stable(dq_addr_o)));

  assert_ready_only_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> !busy_o);
endmodule

bind sgdma_walker sgdma_walker_chk #(.NUM_CH(NUM_CH)) i_chk (.*);

// File: tb/test_sgdma_walker.sv
module test_sgdma_walker;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        start_i = 0;
  logic [0:0]  start_ch_i = 0;
  logic [31:0] table_base_i = 0;
  logic        busy_o;
  logic [1:0]  active_o, fault_o;
  logic        req_valid_i = 0;
  logic        req_ready_o;
  logic [0:0]  req_ch_i = 0;
  logic        req_dir_i = 0;
  logic        resp_valid_o, resp_err_o;
  logic        dq_valid_o;
  logic        dq_ready_i = 0;
  logic [31:0] dq_addr_o;
  logic        dr_valid_i = 0;
  logic [31:0] dr_data_i = 0;
  logic        dv_in_valid_i = 0;
  logic        dv_in_ready_o;
  logic [7:0]  dv_in_data_i = 0;
  logic        dv_out_valid_o;
  logic        dv_out_ready_i = 0;
  logic [7:0]  dv_out_data_o;
  logic        mw_valid_o;
  logic        mw_ready_i = 0;
  logic [31:0] mw_addr_o;
  logic [7:0]  mw_data_o;
  logic        mr_valid_o;
  logic        mr_ready_i = 0;
  logic [31:0] mr_addr_o;
  logic [7:0]  mr_data_i = 0;

  sgdma_walker i_sgdma_walker (.*);

  int checks = 0, fails = 0;
  int n_beats = 0, bad_beats = 0;
  int sect_ch = 0, sect_dir = 0;
  int chain_off [2] = '{0, 0};
  logic [31:0] dq_log [0:15];
  int dq_n = 0;
  logic        dq_pend = 0;
  logic [31:0] dq_pend_addr = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0]  in_byte = 8'h11;

  // vector: {ch, dir, exp_err, exp_active[1:0], exp_beats[9:0]}
  localparam logic [14:0] VEC [0:3] = '{
    {1'b0, 1'b0, 1'b0, 2'b11, 10'd512},
    {1'b1, 1'b1, 1'b0, 2'b11, 10'd512},
    {1'b0, 1'b1, 1'b0, 2'b10, 10'd512},
    {1'b0, 1'b0, 1'b1, 2'b10, 10'd0}
  };

  function automatic logic [31:0] desc_word(input logic [31:0] a);
    case (a)
      32'h1000: return 32'h0000_2001;
      32'h1004: return 32'h0000_0065;
      32'h1008: return 32'h0000_3000;
      32'h100C: return 32'h0000_012C;
      32'h1010: return 32'h0000_4000;
      32'h1014: return 32'h8000_0270;
      32'h1800: return 32'h0000_5000;
      32'h1804: return 32'h8000_0000;
      32'h1900: return 32'h0000_6000;
      32'h1904: return 32'h8000_0100;
      default:  return 32'hDEAD_BEEF;
    endcase
  endfunction

  // address of the k-th chain byte of a channel, from the descriptor table
  function automatic logic [31:0] exp_addr(input int ch, input int k);
    if (ch == 1) return 32'h5000 + 32'(k);
    if (k < 100) return 32'h2000 + 32'(k);
    if (k < 400) return 32'h3000 + 32'(k - 100);
    return 32'h4000 + 32'(k - 400);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // environment: memories, drive, random stalls
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      dr_valid_i = dq_pend;
      dr_data_i  = desc_word(dq_pend_addr);
      dq_pend    = 1'b0;
      dq_ready_i     = lfsr[0] | lfsr[3];
      mw_ready_i     = lfsr[1] | lfsr[5];
      mr_ready_i     = lfsr[2] | lfsr[6];
      dv_out_ready_i = lfsr[4] | lfsr[7];
      dv_in_valid_i  = lfsr[8] | lfsr[9];
      dv_in_data_i   = in_byte;
      mr_data_i      = mr_addr_o[7:0] ^ 8'hA5;
      #0.5;
      if (dq_valid_o && dq_ready_i) begin
        dq_pend = 1'b1;
        dq_pend_addr = dq_addr_o;
        if (dq_n < 16) dq_log[dq_n] = dq_addr_o;
        dq_n++;
      end
      if (mw_valid_o && mw_ready_i) begin
        if (sect_dir != 0 || mw_addr_o != exp_addr(sect_ch, chain_off[sect_ch] + n_beats)
            || mw_data_o != in_byte) bad_beats++;
        n_beats++;
        in_byte = in_byte + 8'd7;
      end
      if (dv_out_valid_o && dv_out_ready_i) begin
        if (sect_dir != 1 || mr_addr_o != exp_addr(sect_ch, chain_off[sect_ch] + n_beats)
            || dv_out_data_o != (mr_addr_o[7:0] ^ 8'hA5)) bad_beats++;
        n_beats++;
      end
    end
  end

  task automatic do_start(input int ch, input logic [31:0] base);
    @(negedge clk);
    start_i = 1; start_ch_i = 1'(ch); table_base_i = base;
    @(negedge clk);
    start_i = 0;
    #1;
    while (busy_o) begin @(negedge clk); #1; end
  endtask

  task automatic do_sector(input int ch, input int dir, output logic err);
    n_beats = 0; bad_beats = 0; sect_ch = ch; sect_dir = dir;
    @(negedge clk);
    req_valid_i = 1; req_ch_i = 1'(ch); req_dir_i = dir[0];
    #1;
    while (!req_ready_o) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid_i = 0;
    #1;
    while (!resp_valid_o) begin @(negedge clk); #1; end
    err = resp_err_o;
    @(negedge clk); #1;
    chain_off[ch] += n_beats;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic err;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R11 reset state
    check(active_o == 2'b00, "R11", "active after reset", active_o, 0);
    check(fault_o == 2'b00, "R11", "fault after reset", fault_o, 0);
    check(!busy_o && !resp_valid_o && !dq_valid_o, "R11", "busy/resp/dq idle",
          {busy_o, resp_valid_o, dq_valid_o}, 0);
    check(req_ready_o, "R11", "request ready", req_ready_o, 1);

    // R1 start both channels
    do_start(0, 32'h1000);
    do_start(1, 32'h1800);
    check(active_o == 2'b11, "R1", "both channels active", active_o, 3);
    check(dq_n == 4 && dq_log[0] == 32'h1000 && dq_log[1] == 32'h1004
          && dq_log[2] == 32'h1800 && dq_log[3] == 32'h1804,
          "R1", "first descriptor words", dq_log[1], 32'h1004);

    // vector walk: R2 R4 R5 R6 R8 R9 R10
    for (int v = 0; v < 4; v++) begin
      do_sector(int'(VEC[v][14]), int'(VEC[v][13]), err);
      check(err == VEC[v][12], "R5/R6", $sformatf("vec%0d error bit", v), err, VEC[v][12]);
      check(n_beats == int'(VEC[v][9:0]), "R4", $sformatf("vec%0d byte count", v),
            n_beats, VEC[v][9:0]);
      check(bad_beats == 0, "R2 R9 R10", $sformatf("vec%0d byte addr/data/dir", v), bad_beats, 0);
      check(active_o == VEC[v][11:10], "R5 R8", $sformatf("vec%0d active flags", v),
            active_o, VEC[v][11:10]);
    end
    // R3 descriptor pointer steps of 8
    check(dq_n == 8 && dq_log[4] == 32'h1008 && dq_log[5] == 32'h100C
          && dq_log[6] == 32'h1010 && dq_log[7] == 32'h1014,
          "R3", "chained descriptor addresses", dq_log[6], 32'h1010);

    // R7 final region too short
    do_start(1, 32'h1900);
    do_sector(1, 0, err);
    check(err == 1'b1, "R7", "short final region error", err, 1);
    check(n_beats == 0, "R7", "no bytes moved on fault", n_beats, 0);
    check(fault_o == 2'b10 && active_o == 2'b00, "R7", "fault set, inactive",
          {fault_o, active_o}, 4'b1000);

    // R1 start and request in the same cycle: start wins
    n_beats = 0; sect_ch = 0; sect_dir = 0;
    @(negedge clk);
    start_i = 1; start_ch_i = 1'b1; table_base_i = 32'h1800;
    req_valid_i = 1; req_ch_i = 1'b0; req_dir_i = 1'b0;
    #1;
    check(!req_ready_o, "R1", "request held off by start", req_ready_o, 0);
    @(negedge clk);
    start_i = 0;
    #1;
    check(busy_o && !resp_valid_o, "R1", "start fetch runs first", {busy_o, resp_valid_o}, 2'b10);
    while (!req_ready_o) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid_i = 0;
    #1;
    while (!resp_valid_o) begin @(negedge clk); #1; end
    check(resp_err_o, "R6", "queued request on inactive channel refused", resp_err_o, 1);
    @(negedge clk); #1;
    check(fault_o == 2'b00 && active_o == 2'b10, "R1", "restart clears fault",
          {fault_o, active_o}, 4'b0010);
    check(n_beats == 0, "R6", "no bytes on refused request", n_beats, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule